// File: doc/BRIEF.md
# Flagged Serial Lane Framer

This block moves a one-way stream of data words across a serializer lane that takes exactly one 16-bit word per clock. On the sending side it wraps each payload word with three in-band control flags (a write strobe, an end-of-stream marker and the sender's own FIFO-full status) and emits one lane word on every cycle. When it has nothing to send, it emits an idle word. On the receiving side it takes the incoming 16-bit word apart. It hands the payload, a valid strobe and the end-of-stream marker to a local consumer. It also remembers the far end's FIFO-full flag, which then throttles the local sender.

All traffic is gated by a link-ready input driven by a separate handshake controller. While that input is low, no word is sent and nothing received is passed on. The payload width is a parameter of at most 13 bits, so that it fits next to the three flags. Both directions run in one synchronous clock domain. The serializer electronics and the handshake itself sit outside this block.

Top module: `lane_framer`

## Requirements
- R1: `lane_tx` is a register that is reloaded on every clock edge. Synchronous active-high reset clears it to all zeros, and a reset also drives `dst_valid`, `dst_eos` and `dst_data` to zero.
- R2: The lane word layout is bit 15 = write strobe, bit 14 = end-of-stream, bit 13 = FIFO-full, and bits [DATA_W-1:0] = payload. Bits 12 down to DATA_W are always zero in transmitted words.
- R3: A word is sent (bit 15 = 1) exactly when `src_valid`, `link_up` and not-remote-full all hold in the cycle before. Otherwise bit 15, bit 14 and the payload bits are all zero.
- R4: `src_ready` is combinational and equals `link_up` AND NOT remote-full. A word is consumed from the source in any cycle where `src_valid` and `src_ready` are both high.
- R5: Bit 13 of every transmitted word, idle or not, equals `dst_full` as sampled at the preceding clock edge.
- R6: The remote-full state is set by reset and by any cycle with `link_up` low. In a cycle with `link_up` high it takes `lane_rx[13]`. After the link comes back, `src_ready` stays low for at least one cycle until a received word clears the state.
- R7: `dst_valid` goes high one clock after a cycle in which `link_up` is high and `lane_rx[15]` is 1. It is low after any other cycle.
- R8: `dst_data` carries `lane_rx[DATA_W-1:0]` with one cycle of latency when `dst_valid` is high, and is zero otherwise. Received bits 12 down to DATA_W are ignored.
- R9: `dst_eos` equals `lane_rx[14]` with one cycle of latency when `dst_valid` is high, and is zero otherwise.
- R10: `DATA_W` lies in the range 1 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link reported connected by the handshake controller |
| src_valid | input | 1 | Source has a word to send |
| src_data | input | DATA_W | Source payload |
| src_eos | input | 1 | Source word ends the stream |
| src_ready | output | 1 | Source word is taken this cycle |
| dst_full | input | 1 | Local receive FIFO is full; echoed to the far end |
| lane_tx | output | 16 | Word to the serializer |
| lane_rx | input | 16 | Word from the deserializer |
| dst_valid | output | 1 | Received payload is valid |
| dst_data | output | DATA_W | Received payload |
| dst_eos | output | 1 | Received word ends the stream |

## Verification
The transmit path is swept over every combination of source valid, end-of-stream, local full, remembered remote-full and link state, each with all payload values of a 4-bit configuration. This separates a word that is sent from the three distinct reasons an idle word is sent, and shows that the full echo does not depend on whether a word is sent. The receive path is swept over all eight flag combinations with every payload value and non-zero garbage in the unused bits, both with the link up and with it down. That tells a valid word from an idle word and from a word arriving on a dead link, and shows that padding bits are dropped. A link drop followed by a reconnect shows that the sender stays blocked until the far end has reported its FIFO state again.

// File: rtl/lane_framer_pkg.sv
package lane_framer_pkg;

    localparam int LANE_W      = 16;
    localparam int FLAG_W      = 3;
    localparam int PAYLOAD_MAX = LANE_W - FLAG_W;

    // Field order is decoded by the far end: keep it fixed.
    typedef struct packed {
        logic                   wen;
        logic                   eos;
        logic                   full;
        logic [PAYLOAD_MAX-1:0] data;
    } lane_word_t;

    localparam lane_word_t IDLE_WORD = '{wen: 1'b0, eos: 1'b0, full: 1'b0, data: '0};

    function automatic lane_word_t to_word(input logic [LANE_W-1:0] raw);
        return lane_word_t'(raw);
    endfunction

endpackage

// File: rtl/lane_flow_gate.sv
module lane_flow_gate
    import lane_framer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic rx_full_flag,
    output logic remote_full,
    output logic send_ok
);

    logic remote_full_q;

    always_ff @(posedge clk) begin
        if (rst || !link_up) begin
            remote_full_q <= 1'b1;
        end else begin
            remote_full_q <= rx_full_flag;
        end
    end

    assign remote_full = remote_full_q;
    assign send_ok     = link_up && !remote_full_q;

endmodule

// File: rtl/lane_tx_packer.sv
module lane_tx_packer
    import lane_framer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_ok,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_eos,
    input  logic              local_full,
    output lane_word_t        word_q
);

    logic       fire;
    lane_word_t word_d;

    assign fire = src_valid && send_ok;

    always_comb begin
        word_d      = IDLE_WORD;
        word_d.full = local_full;
        if (fire) begin
            word_d.wen              = 1'b1;
            word_d.eos              = src_eos;
            word_d.data[DATA_W-1:0] = src_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= IDLE_WORD;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/lane_rx_unpacker.sv
module lane_rx_unpacker
    import lane_framer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  lane_word_t        rx_word,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_eos
);

    logic take;

    assign take = link_up && rx_word.wen;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_valid <= 1'b0;
            dst_data  <= '0;
            dst_eos   <= 1'b0;
        end else begin
            dst_valid <= take;
            dst_data  <= take ? rx_word.data[DATA_W-1:0] : '0;
            dst_eos   <= take && rx_word.eos;
        end
    end

endmodule

// File: rtl/lane_framer.sv
module lane_framer
    import lane_framer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_eos,
    output logic              src_ready,
    input  logic              dst_full,
    output logic [15:0]       lane_tx,
    input  logic [15:0]       lane_rx,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_eos
);

    lane_word_t rx_word;
    lane_word_t tx_word;
    logic       remote_full;
    logic       send_ok;

    assign rx_word = to_word(lane_rx);

    lane_flow_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .link_up      (link_up),
        .rx_full_flag (rx_word.full),
        .remote_full  (remote_full),
        .send_ok      (send_ok)
    );

    lane_tx_packer #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .send_ok    (send_ok),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_eos    (src_eos),
        .local_full (dst_full),
        .word_q     (tx_word)
    );

    lane_rx_unpacker #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .rx_word   (rx_word),
        .dst_valid (dst_valid),
        .dst_data  (dst_data),
        .dst_eos   (dst_eos)
    );

    assign src_ready = send_ok;
    assign lane_tx   = tx_word;

endmodule

// File: rtl/lane_framer_checker.sv
module lane_framer_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              link_up,
    input logic              src_valid,
    input logic              src_ready,
    input logic              dst_full,
    input logic [15:0]       lane_tx,
    input logic [15:0]       lane_rx,
    input logic              dst_valid,
    input logic [DATA_W-1:0] dst_data,
    input logic              dst_eos
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    initial begin
        a_r10_width_range: assert (DATA_W >= 1 && DATA_W <= 13)
            else $error("DATA_W out of range");
    end

    // R3: nothing is sent on a dead link
    a_r3_no_send_link_down: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !lane_tx[15]);

    // R3: idle word carries no eos
    a_r3_idle_no_eos: assert property (@(posedge clk) disable iff (rst)
        !lane_tx[15] |-> !lane_tx[14]);

    // R4: ready needs the link
    a_r4_ready_needs_link: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> link_up);

    // R5: full echo
    a_r5_full_echo: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> lane_tx[13] == $past(dst_full));

    // R6: blocked right after link returns
    a_r6_block_after_drop: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !src_ready);

    // R7: accepted word gives valid
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (link_up && lane_rx[15]) |=> dst_valid);

    // R7: no valid from a dead link
    a_r7_no_valid_down: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !dst_valid);

    // R9: eos only with valid
    a_r9_eos_with_valid: assert property (@(posedge clk) disable iff (rst)
        dst_eos |-> dst_valid);

    // R8: payload zero when not valid
    a_r8_data_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !dst_valid |-> dst_data == '0);

    generate
        if (DATA_W < 13) begin : g_pad
            // R2: padding bits stay zero
            a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
                lane_tx[12:DATA_W] == '0);
        end
    endgenerate

endmodule

bind lane_framer lane_framer_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_up   (link_up),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .dst_full  (dst_full),
    .lane_tx   (lane_tx),
    .lane_rx   (lane_rx),
    .dst_valid (dst_valid),
    .dst_data  (dst_data),
    .dst_eos   (dst_eos)
);

// File: tb/lane_framer_bench.sv
`timescale 1ns/1ps
module lane_framer_bench;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          link_up;
    logic          src_valid;
    logic [DW-1:0] src_data;
    logic          src_eos;
    logic          src_ready;
    logic          dst_full;
    logic [15:0]   lane_tx;
    logic [15:0]   lane_rx;
    logic          dst_valid;
    logic [DW-1:0] dst_data;
    logic          dst_eos;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lane_framer #(.DATA_W(DW)) u_lane_framer (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_eos   (src_eos),
        .src_ready (src_ready),
        .dst_full  (dst_full),
        .lane_tx   (lane_tx),
        .lane_rx   (lane_rx),
        .dst_valid (dst_valid),
        .dst_data  (dst_data),
        .dst_eos   (dst_eos)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        n_vec++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        link_up   = 1'b1;
        src_valid = 1'b1;
        src_data  = '1;
        src_eos   = 1'b1;
        dst_full  = 1'b1;
        lane_rx   = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 lane_tx reset", 32'(lane_tx), 32'h0);
        check("R1 dst_valid reset", 32'(dst_valid), 32'h0);
        check("R1 dst_data reset", 32'(dst_data), 32'h0);
        check("R6 src_ready in reset", 32'(src_ready), 32'h0);
        rst = 1'b0;
        src_valid = 1'b0;

        // Transmit sweep: R2 R3 R4 R5
        for (int rf = 0; rf < 2; rf++)
        for (int lk = 0; lk < 2; lk++)
        for (int sv = 0; sv < 2; sv++)
        for (int se = 0; se < 2; se++)
        for (int df = 0; df < 2; df++)
        for (int d = 0; d < 16; d++) begin
            logic fire;
            logic [15:0] exp;
            @(negedge clk);
            link_up   = 1'b1;
            src_valid = 1'b0;
            lane_rx   = {2'b00, 1'(rf), 13'd0};
            @(negedge clk);
            link_up   = 1'(lk);
            src_valid = 1'(sv);
            src_eos   = 1'(se);
            dst_full  = 1'(df);
            src_data  = 4'(d);
            #1;
            check("R4 src_ready", 32'(src_ready), 32'(lk == 1 && rf == 0));
            fire = (sv == 1) && (lk == 1) && (rf == 0);
            exp  = {fire, fire & 1'(se), 1'(df), 9'd0, fire ? 4'(d) : 4'd0};
            @(negedge clk);
            check("R3 R2 R5 lane_tx", 32'(lane_tx), 32'(exp));
        end

        // Receive sweep: R7 R8 R9
        src_valid = 1'b0;
        for (int lk = 0; lk < 2; lk++)
        for (int f = 0; f < 8; f++)
        for (int d = 0; d < 16; d++) begin
            logic [8:0] junk;
            logic v;
            junk = 9'((d * 37 + f * 11 + 1) & 9'h1FF);
            @(negedge clk);
            link_up = 1'(lk);
            lane_rx = {3'(f), junk, 4'(d)};
            @(negedge clk);
            v = (lk == 1) && f[2];
            check("R7 dst_valid", 32'(dst_valid), 32'(v));
            check("R8 dst_data", 32'(dst_data), v ? 32'(d) : 32'h0);
            check("R9 dst_eos", 32'(dst_eos), 32'(v && f[1]));
        end

        // Reconnect: R6
        @(negedge clk);
        link_up = 1'b0;
        lane_rx = 16'h0000;
        @(negedge clk);
        link_up = 1'b1;
        #1;
        check("R6 blocked after reconnect", 32'(src_ready), 32'h0);
        @(negedge clk);
        check("R6 ready after far status", 32'(src_ready), 32'h1);
        lane_rx = 16'h2000;
        @(negedge clk);
        check("R6 remote full blocks", 32'(src_ready), 32'h0);

        // Back-to-back stream words: R1 R3
        lane_rx = 16'h0000;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            src_valid = 1'b1;
            src_data  = 4'(k + 9);
            src_eos   = (k == 3);
            dst_full  = 1'b0;
            @(negedge clk);
            check("R1 R3 streaming word", 32'(lane_tx),
                  32'({1'b1, (k == 3), 1'b0, 9'd0, 4'(k + 9)}));
        end
        src_valid = 1'b0;
        @(negedge clk);
        check("R3 idle after stream", 32'(lane_tx), 32'h0);

        finish_run();
    end

endmodule